// File: doc/BRIEF.md
# Strobe-Sequenced Fuse Array Read Controller

This block lets software read a one-time-programmable fuse array through two registers on a simple register bus. Software writes a control word that sets the operating mode (chip select, read enable, program-enable guard), places a fuse address in a field whose position depends on the chosen variant, and sets a strobe bit. A rising strobe in a legal read mode starts an array access. After a fixed number of clock cycles the addressed fuse value appears in a read-only data register and a busy flag drops. A strobe in any other mode (standby, power-down, inactive, or with the program guard low) leaves the array and the data register untouched.

Four variants are selected by a parameter. Three return one byte per address, with the address field starting at bit 8, 7 or 6. The fourth returns a 32-bit word per address and adds a power-down control bit. The array itself is a synchronous read-only model whose content is a fixed arithmetic function of the address and a seed parameter. Programming fuses is outside this block.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: After reset the control register reads 0x0000_0009 (standby: chip select bit 0 high, program guard bit 3 high), the data register reads 0 and busy is low.
- R2: Bus offset 0x0 is the control register, fully writable and read back as written. Offset 0x4 is the read-only data register; writes to it are ignored. Any other offset reads 0. Read data appears the clock edge after the read request.
- R3: Control bit 0 is the active-low chip select, bit 1 the strobe, bit 2 the read-enable (load) and bit 3 the active-high program guard. The address field is bits 15:8 for VARIANT 0, 15:7 for VARIANT 1, 15:6 for VARIANT 2 and 25:16 for VARIANT 3. Bit 5 is power-down in VARIANT 3 only; other variants ignore it.
- R4: A control write that changes the strobe from 0 to 1 while the written word has load 1, chip select 0, program guard 1 and (VARIANT 3) power-down 0 starts a read: busy is high from that write's clock edge, and LATENCY edges later busy falls and the data register takes the new value.
- R5: The fuse value at address a is w = (a * 0x9E3779B1) ^ SEED modulo 2^32. VARIANT 3 returns w; byte variants return w[7:0] with bits 31:8 of the data register zero.
- R6: A strobe written with the program guard low starts no read, keeps busy low and leaves the data register unchanged.
- R7: A strobe written with chip select high, load low, or (VARIANT 3) power-down high starts no read; this covers standby (0x9), power-down (0x21) and inactive (0x0) encodings.
- R8: Rewriting the control register while its strobe is already 1 starts no read; the strobe must be cleared and set again.
- R9: A qualifying strobe written while busy is high is ignored; the running read finishes on time with its original address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write request |
| bus_rd | input | 1 | Register read request |
| bus_addr | input | BUS_AW | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| busy | output | 1 | High while an array read is in progress |

## Verification
Busy is due high one edge after the starting control write and low exactly LATENCY edges after it, so the bench samples at the falling edge following the write, again at the falling edge before the deadline and once more after it. Read data is registered, so each register read is sampled at the falling edge after the request edge. Blocked strobes are checked by waiting beyond LATENCY and then reading the data register, whose expected value the bench carries from the last legal read. Both a word variant and a byte variant are swept over every address, with expected values computed from the formula in R5.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

  // Register offsets on the bus
  localparam int CTRL_OFF = 0;
  localparam int DOUT_OFF = 4;

  // Control bits whose position the sequencing depends on
  localparam int BIT_CSB   = 0;
  localparam int BIT_STB   = 1;
  localparam int BIT_LOAD  = 2;
  localparam int BIT_PGENB = 3;
  localparam int BIT_PD    = 5;

  localparam logic [31:0] CTRL_RST = 32'h0000_0009;
  localparam logic [31:0] HASH_MUL = 32'h9E37_79B1;

  function automatic int addr_lsb(input int variant);
    case (variant)
      0:       return 8;
      1:       return 7;
      2:       return 6;
      default: return 16;
    endcase
  endfunction

  function automatic int addr_bits(input int variant);
    case (variant)
      0:       return 8;
      1:       return 9;
      default: return 10;
    endcase
  endfunction

  function automatic int data_bits(input int variant);
    return (variant == 3) ? 32 : 8;
  endfunction

  function automatic logic [31:0] fuse_word(input logic [31:0] a, input logic [31:0] seed);
    return (a * HASH_MUL) ^ seed;
  endfunction

endpackage

// File: rtl/fuse_rom.sv
module fuse_rom
  import fuse_pkg::*;
#(
  parameter int          AW   = 10,
  parameter int          DW   = 32,
  parameter logic [31:0] SEED = 32'h5A5A_0F0F
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] data
);

  // Synchronous read of a computed image, one register stage
  always_ff @(posedge clk) begin
    data <= DW'(fuse_word(32'(addr), SEED));
  end

endmodule

// File: rtl/fuse_seq.sv
module fuse_seq #(
  parameter int AW      = 10,
  parameter int DW      = 32,
  parameter int LATENCY = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] rom_data,
  output logic [AW-1:0] rom_addr,
  output logic          busy,
  output logic [DW-1:0] dout
);

  // The array has one register stage, so two cycles is the floor
  localparam int EFF_LAT = (LATENCY < 2) ? 2 : LATENCY;
  localparam int CW      = $clog2(EFF_LAT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cnt_q    <= '0;
      rom_addr <= '0;
      dout     <= '0;
    end else if (start && !busy) begin
      busy     <= 1'b1;
      cnt_q    <= CW'(EFF_LAT);
      rom_addr <= start_addr;
    end else if (busy) begin
      if (cnt_q == CW'(1)) begin
        busy  <= 1'b0;
        cnt_q <= '0;
        dout  <= rom_data;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // Data register moves only when a read completes
  assert_dout_only_on_done_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(dout) |-> $fell(busy));

  // Completed value comes from the array output
  assert_dout_from_array_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (dout == $past(rom_data)));

  // Address under access is frozen while busy
  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(rom_addr));

endmodule

// File: rtl/fuse_regs.sv
module fuse_regs
  import fuse_pkg::*;
#(
  parameter int VARIANT = 3,
  parameter int BUS_AW  = 4,
  parameter int AW      = 10,
  parameter int ALSB    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BUS_AW-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [31:0]       dout_word,
  input  logic              busy,
  output logic [31:0]       rdata,
  output logic              start,
  output logic [AW-1:0]     start_addr
);

  localparam logic [BUS_AW-1:0] OFF_C = BUS_AW'(CTRL_OFF);
  localparam logic [BUS_AW-1:0] OFF_D = BUS_AW'(DOUT_OFF);

  logic [31:0] ctrl_q;
  logic        ctrl_wr;
  logic        pd_clear;
  logic        mode_ok;
  logic        stb_rise;

  assign ctrl_wr = wr_en && (addr == OFF_C);

  generate
    if (VARIANT == 3) begin : g_pd
      assign pd_clear = !wdata[BIT_PD];
    end else begin : g_no_pd
      assign pd_clear = 1'b1;
    end
  endgenerate

  assign mode_ok    = wdata[BIT_LOAD] && !wdata[BIT_CSB] && wdata[BIT_PGENB] && pd_clear;
  assign stb_rise   = wdata[BIT_STB] && !ctrl_q[BIT_STB];
  assign start      = ctrl_wr && stb_rise && mode_ok && !busy;
  assign start_addr = wdata[ALSB +: AW];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
    end else if (ctrl_wr) begin
      ctrl_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        OFF_C:   rdata <= ctrl_q;
        OFF_D:   rdata <= dout_word;
        default: rdata <= '0;
      endcase
    end
  end

  assert_rdata_dout_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFF_D) |=> (rdata == $past(dout_word)));

  assert_pgenb_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !wdata[BIT_PGENB] && !busy) |=> !busy);

  assert_csb_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && wdata[BIT_CSB] && !busy) |=> !busy);

  assert_no_rearm_R8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && ctrl_q[BIT_STB] && !busy) |=> !busy);

endmodule

// File: rtl/fuse_rd_ctrl.sv
module fuse_rd_ctrl
  import fuse_pkg::*;
#(
  parameter int          VARIANT = 3,
  parameter int          LATENCY = 4,
  parameter logic [31:0] SEED    = 32'h5A5A_0F0F,
  parameter int          BUS_AW  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              busy
);

  localparam int AW   = addr_bits(VARIANT);
  localparam int ALSB = addr_lsb(VARIANT);
  localparam int DW   = data_bits(VARIANT);

  logic          start;
  logic [AW-1:0] start_addr;
  logic [AW-1:0] rom_addr;
  logic [DW-1:0] rom_data;
  logic [DW-1:0] dout;
  logic [31:0]   dout_word;

  generate
    if (DW == 32) begin : g_word
      assign dout_word = dout;
    end else begin : g_byte
      assign dout_word = {{(32-DW){1'b0}}, dout};
    end
  endgenerate

  fuse_regs #(
    .VARIANT (VARIANT),
    .BUS_AW  (BUS_AW),
    .AW      (AW),
    .ALSB    (ALSB)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (bus_wr),
    .rd_en      (bus_rd),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .dout_word  (dout_word),
    .busy       (busy),
    .rdata      (bus_rdata),
    .start      (start),
    .start_addr (start_addr)
  );

  fuse_seq #(
    .AW      (AW),
    .DW      (DW),
    .LATENCY (LATENCY)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_addr (start_addr),
    .rom_data   (rom_data),
    .rom_addr   (rom_addr),
    .busy       (busy),
    .dout       (dout)
  );

  fuse_rom #(
    .AW   (AW),
    .DW   (DW),
    .SEED (SEED)
  ) u_rom (
    .clk  (clk),
    .addr (rom_addr),
    .data (rom_data)
  );

  generate
    if (DW < 32) begin : g_chk_byte
      assert_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == BUS_AW'(DOUT_OFF)) |=> (bus_rdata[31:8] == 24'h0));
    end
  endgenerate

endmodule

// File: tb/tb_fuse_rd_ctrl.sv
module tb_fuse_rd_ctrl;

  localparam int          LW     = 5;
  localparam int          LB     = 3;
  localparam logic [31:0] SEED   = 32'h5A5A_0F0F;
  localparam logic [31:0] BASE_W = 32'h0000_028C; // load, guard, bits 7 and 9
  localparam logic [31:0] BASE_B = 32'h0000_000C; // load, guard

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_w = 1'b0, rd_w = 1'b0, wr_b = 1'b0, rd_b = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_w, rdata_b;
  logic        busy_w, busy_b;
  logic [31:0] last_w = '0, last_b = '0;
  int          errors = 0, checks = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  fuse_rd_ctrl #(.VARIANT(3), .LATENCY(LW), .SEED(SEED), .BUS_AW(4)) dut (
    .clk(clk), .rst(rst), .bus_wr(wr_w), .bus_rd(rd_w), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata_w), .busy(busy_w));

  fuse_rd_ctrl #(.VARIANT(1), .LATENCY(LB), .SEED(SEED), .BUS_AW(4)) dut_b (
    .clk(clk), .rst(rst), .bus_wr(wr_b), .bus_rd(rd_b), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata_b), .busy(busy_b));

  function automatic logic [31:0] exp_word(input int a);
    logic [31:0] av;
    av = 32'(a);
    return (av * 32'h9E37_79B1) ^ SEED;
  endfunction

  function automatic logic busy_of(input bit b);
    return b ? busy_b : busy_w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input bit b, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (b) wr_b = 1'b1; else wr_w = 1'b1;
    @(negedge clk);
    wr_b = 1'b0; wr_w = 1'b0;
  endtask

  task automatic rd(input bit b, input logic [3:0] a, output logic [31:0] q);
    @(negedge clk);
    addr = a;
    if (b) rd_b = 1'b1; else rd_w = 1'b1;
    @(negedge clk);
    rd_b = 1'b0; rd_w = 1'b0;
    q = b ? rdata_b : rdata_w;
  endtask

  // Legal read: strobe rise, busy timing, data from the formula, strobe clear
  task automatic do_read(input bit b, input int a, input logic [31:0] extra, input string req);
    int          lat;
    int          sh;
    logic [31:0] base, got, exp;
    lat  = b ? LB : LW;
    sh   = b ? 7 : 16;
    base = (b ? BASE_B : BASE_W) | extra;
    exp  = b ? (exp_word(a) & 32'hFF) : exp_word(a);
    wr(b, 4'h0, base | (32'(a) << sh) | 32'h2);
    check({req, " R4 busy after strobe"}, 32'(busy_of(b)), 32'h1);
    repeat (lat - 1) @(negedge clk);
    check({req, " R4 busy before deadline"}, 32'(busy_of(b)), 32'h1);
    @(negedge clk);
    check({req, " R4 busy cleared at deadline"}, 32'(busy_of(b)), 32'h0);
    rd(b, 4'h4, got);
    check({req, " R5 fuse data"}, got, exp);
    if (b) last_b = exp; else last_w = exp;
    wr(b, 4'h0, base | (32'(a) << sh));
  endtask

  // Strobe in a mode that must not read
  task automatic blocked(input bit b, input logic [31:0] val, input string req);
    int          lat;
    logic [31:0] got;
    lat = b ? LB : LW;
    wr(b, 4'h0, 32'h0);
    wr(b, 4'h0, val);
    check({req, " busy stays low"}, 32'(busy_of(b)), 32'h0);
    repeat (lat + 2) @(negedge clk);
    check({req, " busy still low"}, 32'(busy_of(b)), 32'h0);
    rd(b, 4'h4, got);
    check({req, " data unchanged"}, got, b ? last_b : last_w);
    wr(b, 4'h0, 32'h0);
  endtask

  initial begin
    logic [31:0] got;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(0, 4'h0, got); check("R1 word ctrl reset", got, 32'h9);
    rd(0, 4'h4, got); check("R1 word dout reset", got, 32'h0);
    check("R1 word busy reset", 32'(busy_w), 32'h0);
    rd(1, 4'h0, got); check("R1 byte ctrl reset", got, 32'h9);
    rd(1, 4'h4, got); check("R1 byte dout reset", got, 32'h0);
    check("R1 byte busy reset", 32'(busy_b), 32'h0);

    // R2 register map
    wr(0, 4'h0, 32'hDEAD_0001);
    rd(0, 4'h0, got); check("R2 ctrl readback", got, 32'hDEAD_0001);
    rd(0, 4'h8, got); check("R2 unmapped offset", got, 32'h0);
    wr(0, 4'h0, 32'h0);

    // R3/R5 full sweeps of both variants
    for (int a = 0; a < 1024; a++) do_read(0, a, 32'h0, "R3 word sweep");
    for (int a = 0; a < 512; a++)  do_read(1, a, 32'h0, "R3 byte sweep");

    // R2 data register is read-only
    wr(0, 4'h4, 32'hFFFF_FFFF);
    rd(0, 4'h4, got); check("R2 dout write ignored", got, last_w);
    wr(1, 4'h4, 32'hFFFF_FFFF);
    rd(1, 4'h4, got); check("R2 byte dout write ignored", got, last_b);

    // R3 bit 5 has no power-down meaning in a byte variant
    do_read(1, 77, 32'h20, "R3 byte bit5 ignored");

    // R6 program guard low
    blocked(0, (BASE_W & ~32'h8) | (32'd12 << 16) | 32'h2, "R6 word guard low");
    blocked(1, (BASE_B & ~32'h8) | (32'd12 << 7) | 32'h2, "R6 byte guard low");

    // R7 non-read modes
    blocked(0, BASE_W | 32'h1 | 32'h2, "R7 word csb high");
    blocked(0, (BASE_W & ~32'h4) | 32'h2, "R7 word load low");
    blocked(0, BASE_W | 32'h20 | 32'h2, "R7 word power-down bit");
    blocked(0, 32'h0000_000B, "R7 word standby");
    blocked(0, 32'h0000_0023, "R7 word power-down mode");
    blocked(0, 32'h0000_0002, "R7 word inactive");
    blocked(1, 32'h0000_000B, "R7 byte standby");
    blocked(1, 32'h0000_0002, "R7 byte inactive");

    // R8 strobe already high: no new read
    wr(0, 4'h0, BASE_W | (32'd100 << 16) | 32'h2);
    repeat (LW + 1) @(negedge clk);
    last_w = exp_word(100);
    wr(0, 4'h0, BASE_W | (32'd200 << 16) | 32'h2);
    check("R8 busy stays low", 32'(busy_w), 32'h0);
    repeat (LW + 1) @(negedge clk);
    rd(0, 4'h4, got); check("R8 data from first read", got, exp_word(100));
    wr(0, 4'h0, 32'h0);

    // R9 strobe during busy is ignored
    wr(0, 4'h0, BASE_W | (32'd300 << 16) | 32'h2);   // edge N
    check("R9 busy after start", 32'(busy_w), 32'h1);
    wr(0, 4'h0, BASE_W | (32'd400 << 16));           // edge N+2
    wr(0, 4'h0, BASE_W | (32'd400 << 16) | 32'h2);   // edge N+4
    check("R9 busy before deadline", 32'(busy_w), 32'h1);
    @(negedge clk);
    check("R9 busy falls on time", 32'(busy_w), 32'h0);
    repeat (LW + 1) @(negedge clk);
    check("R9 no restart", 32'(busy_w), 32'h0);
    rd(0, 4'h4, got); check("R9 original address kept", got, exp_word(300));
    last_w = exp_word(300);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule